// File: doc/BRIEF.md
# Single-Wire Bus Device Responder

This block is the device end of a single open-drain data line that a remote master pulls low and a resistor pulls high. It passes the line through a synchronizer and measures how long each low period lasts. A long enough low period counts as a bus reset. When the line is released after a reset, the block waits briefly and then pulls the line low for a fixed time to announce that a device is present.

Apart from resets, each falling edge from the master opens a bit slot, and the slot is timed from that edge. Before the edge, the logic above the block sets the slot direction and, for a read, the bit to send. In a write slot the block samples the line a fixed time after the edge and reports the bit with a one-cycle strobe. In a read slot a 0 is sent by holding the line low for that same delay, and a 1 is sent by leaving the line alone. All timing uses a microsecond tick divided down from the clock.

Top module: `ow_responder`

## Requirements
- R1: During and right after reset (rst_n low) the block does not drive the line, and rx_valid_o and reset_seen_o are low.
- R2: When the line has been low for at least RESET_US (480) microseconds and then rises, reset_seen_o pulses high for exactly one clock. It never pulses in the same cycle as rx_valid_o.
- R3: After a reset is seen, line_pull_o stays low for PDH_US (30) microseconds, then stays high for PDL_US (120) microseconds, then returns low. Timing is within one microsecond plus synchronizer delay.
- R4: A low period shorter than RESET_US does not produce reset_seen_o and does not produce a presence pulse.
- R5: A slot whose slot_dir_i is 0 (write) at the falling edge gives one rx_valid_o pulse of a single clock, SLOT_US (30) microseconds after the edge. rx_bit_o equals the sampled line level (1 = high), and the block does not drive the line during a write slot.
- R6: A slot whose slot_dir_i is 1 (read) with tx_bit_i 0 drives line_pull_o high within one microsecond of the edge and keeps it high until SLOT_US microseconds after the edge, then releases it.
- R7: A read slot with tx_bit_i 1 never drives the line. Read slots of either value produce no rx_valid_o pulse.
- R8: slot_dir_i and tx_bit_i are captured at the falling edge. Changes to them later in the same slot have no effect on that slot.
- R9: If the line stays low for RESET_US during any slot, including a read-0 slot, the slot is abandoned, the low period is treated as a reset, and a presence pulse follows.
- R10: Falling edges that occur while the block is itself pulling the line low are ignored. A master pulse inside the presence pulse neither opens a slot nor shortens the presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Level seen on the open-drain data line |
| line_pull_o | output | 1 | 1 = pull the data line low |
| slot_dir_i | input | 1 | Direction of the next slot: 0 write (master to device), 1 read (device to master) |
| tx_bit_i | input | 1 | Bit to return in the next read slot |
| rx_valid_o | output | 1 | One-clock strobe at the write-slot sample point |
| rx_bit_o | output | 1 | Bit captured in the last write slot |
| reset_seen_o | output | 1 | One-clock pulse when the line rises after a reset |

## Verification
The hardest case to reach is a master edge that arrives while the device is already pulling the line low. On the wired line such an edge is hidden, so the bench places a master pulse in the middle of the presence pulse. It then checks that no write strobe appears and that the release time does not change. A reset that starts as a read-0 slot is also hard to reach, because the device's own hold and the master's long low overlap. The bench sets up a read-0 slot and keeps the master low past the reset threshold. The rest of the stimulus is a seeded random mix of write and read slots with random low widths, and the slot inputs are flipped partway through each slot.

// File: rtl/ow_pkg.sv
package ow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // line high, waiting for a master edge
        ST_SLOT,   // timing the delay from the edge
        ST_HOLD,   // waiting for line high, watching for a reset-length low
        ST_RSTW,   // reset detected, waiting for the line to rise
        ST_PWAIT,  // gap before presence
        ST_PLOW    // presence pulse driven
    } ow_state_e;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], line_i};
    end

    assign line_s = sh_q[STAGES-1];
    assign fall   = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/ow_tick.sv
module ow_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n)             pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ow_responder.sv
module ow_responder
    import ow_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int RESET_US   = 480,
    parameter int PDH_US     = 30,
    parameter int PDL_US     = 120,
    parameter int SLOT_US    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_pull_o,
    input  logic slot_dir_i,
    input  logic tx_bit_i,
    output logic rx_valid_o,
    output logic rx_bit_o,
    output logic reset_seen_o
);
    localparam int CNT_W = $clog2(RESET_US + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] T_RST   = CNT_W'(RESET_US);
    localparam logic [CNT_W-1:0] T_PDH   = CNT_W'(PDH_US);
    localparam logic [CNT_W-1:0] T_PDL   = CNT_W'(PDL_US);
    localparam logic [CNT_W-1:0] T_SLOT  = CNT_W'(SLOT_US);

    typedef struct packed {
        ow_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             bitv;
        logic             pull;
        logic             rxv;
        logic             rxb;
        logic             rseen;
    } ow_regs_t;

    localparam ow_regs_t REGS_RST = '{st: ST_IDLE, cnt: '0, dir: 1'b0, bitv: 1'b1,
                                      pull: 1'b0, rxv: 1'b0, rxb: 1'b0, rseen: 1'b0};

    logic line_s, fall, tick;
    ow_regs_t r_d, r_q;

    ow_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_s(line_s), .fall(fall)
    );

    ow_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rxv   = 1'b0;
        r_d.rseen = 1'b0;
        if (tick && r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + 1'b1;
        case (r_q.st)
            ST_IDLE: begin
                r_d.cnt  = '0;
                r_d.pull = 1'b0;
                if (fall) begin
                    r_d.st   = ST_SLOT;
                    r_d.dir  = slot_dir_i;
                    r_d.bitv = tx_bit_i;
                    r_d.pull = slot_dir_i & ~tx_bit_i;
                end
            end
            ST_SLOT: begin
                if (r_q.cnt >= T_SLOT) begin
                    r_d.pull = 1'b0;
                    r_d.st   = ST_HOLD;
                    if (!r_q.dir) begin
                        r_d.rxv = 1'b1;
                        r_d.rxb = line_s;
                    end
                end
            end
            ST_HOLD: begin
                if (line_s) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else if (r_q.cnt >= T_RST) begin
                    r_d.st = ST_RSTW;
                end
            end
            ST_RSTW: begin
                if (line_s) begin
                    r_d.rseen = 1'b1;
                    r_d.st    = ST_PWAIT;
                    r_d.cnt   = '0;
                end
            end
            ST_PWAIT: begin
                if (r_q.cnt >= T_PDH) begin
                    r_d.st   = ST_PLOW;
                    r_d.cnt  = '0;
                    r_d.pull = 1'b1;
                end
            end
            ST_PLOW: begin
                if (r_q.cnt >= T_PDL) begin
                    r_d.pull = 1'b0;
                    r_d.st   = ST_HOLD;
                    r_d.cnt  = '0;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign line_pull_o  = r_q.pull;
    assign rx_valid_o   = r_q.rxv;
    assign rx_bit_o     = r_q.rxb;
    assign reset_seen_o = r_q.rseen;
endmodule

// File: rtl/ow_responder_chk.sv
module ow_responder_chk #(
    parameter int CLK_PER_US = 100,
    parameter int PDL_US     = 120
) (
    input logic clk,
    input logic rst_n,
    input logic line_pull_o,
    input logic rx_valid_o,
    input logic reset_seen_o
);
    localparam int LIM   = (PDL_US + 2) * CLK_PER_US;
    localparam int RUN_W = $clog2(LIM + 4) + 1;
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(LIM);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= '0;
        else if (!line_pull_o)               run_q <= '0;
        else if (run_q != RUN_MAX)           run_q <= run_q + 1'b1;
    end

    assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_seen_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen_o |=> !reset_seen_o);

    assert_seen_not_with_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_seen_o && rx_valid_o));

    assert_seen_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen_o |-> !line_pull_o);

    assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !line_pull_o);

    assert_pull_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LIM);
endmodule

bind ow_responder ow_responder_chk #(
    .CLK_PER_US(CLK_PER_US),
    .PDL_US(PDL_US)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .line_pull_o(line_pull_o),
    .rx_valid_o(rx_valid_o),
    .reset_seen_o(reset_seen_o)
);

// File: tb/sim_ow_responder.sv
module sim_ow_responder;
    localparam int CPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic slot_dir = 1'b0;
    logic tx_bit = 1'b1;
    logic line_i, line_pull_o, rx_valid_o, rx_bit_o, reset_seen_o;

    int checks = 0;
    int fails = 0;
    int rx_cnt = 0;
    int rs_cnt = 0;
    logic rx_last = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign line_i = ~(m_low | line_pull_o);

    ow_responder #(.CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_pull_o(line_pull_o),
        .slot_dir_i(slot_dir), .tx_bit_i(tx_bit), .rx_valid_o(rx_valid_o),
        .rx_bit_o(rx_bit_o), .reset_seen_o(reset_seen_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid_o) begin
                rx_cnt <= rx_cnt + 1;
                rx_last <= rx_bit_o;
            end
            if (reset_seen_o) rs_cnt <= rs_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    // Reset pulse of low_us, then presence checks; inject puts a master pulse inside presence.
    task automatic do_reset(input int low_us, input bit inject, input string tag);
        int rs0;
        int rx0;
        rs0 = rs_cnt;
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        wait_us(2);
        chk(rs_cnt == rs0 + 1, {tag, " reset seen once"}, rs_cnt, rs0 + 1);
        rx0 = rx_cnt;
        wait_us(18);
        chk(line_pull_o == 1'b0, {tag, " R3 gap before presence"}, line_pull_o, 0);
        wait_us(20);
        chk(line_pull_o == 1'b1, {tag, " R3 presence start"}, line_pull_o, 1);
        if (inject) begin
            m_low = 1'b1;
            wait_us(10);
            m_low = 1'b0;
            wait_us(90);
        end else begin
            wait_us(100);
        end
        chk(line_pull_o == 1'b1, {tag, " R3 presence held"}, line_pull_o, 1);
        wait_us(25);
        chk(line_pull_o == 1'b0, {tag, " R3 presence end"}, line_pull_o, 0);
        if (inject) chk(rx_cnt == rx0, "R10 no slot from hidden edge", rx_cnt, rx0);
        wait_us(5);
    endtask

    task automatic do_slot(input bit dir, input bit b);
        int rx0;
        int low;
        int e;
        string tag;
        rx0 = rx_cnt;
        tag = dir ? (b ? "R7" : "R6") : "R5";
        slot_dir = dir;
        tx_bit = b;
        @(negedge clk);
        m_low = 1'b1;
        if (dir)    low = 1;
        else if (b) low = 2 + int'($urandom % 8);
        else        low = 45 + int'($urandom % 20);
        wait_us(1);
        slot_dir = ~dir;   // R8: late changes must not matter
        tx_bit = ~b;
        wait_us(low - 1);
        m_low = 1'b0;
        e = low;
        if (dir) begin
            wait_us(15 - e);
            chk(line_i == b, {tag, " R8 read level mid-slot"}, line_i, b);
            e = 15;
        end
        wait_us(75 - e);
        if (!dir) begin
            chk(rx_cnt == rx0 + 1, "R5 one strobe per write slot", rx_cnt, rx0 + 1);
            chk(rx_last == b, "R5 R8 write bit value", rx_last, b);
        end else begin
            chk(rx_cnt == rx0, "R7 no strobe in read slot", rx_cnt, rx0);
        end
        chk(line_pull_o == 1'b0, {tag, " line released after slot"}, line_pull_o, 0);
        wait_us(3);
    endtask

    initial begin
        int rs0;
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        chk(line_pull_o == 1'b0, "R1 no drive in reset", line_pull_o, 0);
        chk(rx_valid_o == 1'b0, "R1 no strobe in reset", rx_valid_o, 0);
        chk(reset_seen_o == 1'b0, "R1 no reset flag in reset", reset_seen_o, 0);
        rst_n = 1'b1;
        wait_us(5);
        chk(line_pull_o == 1'b0, "R1 idle after reset", line_pull_o, 0);

        slot_dir = 1'b0;
        do_reset(500, 1'b0, "R2");

        do_slot(1'b0, 1'b1);
        do_slot(1'b0, 1'b0);
        do_slot(1'b1, 1'b0);
        do_slot(1'b1, 1'b1);

        // R4: long but sub-reset low
        rs0 = rs_cnt;
        slot_dir = 1'b0;
        m_low = 1'b1;
        wait_us(400);
        m_low = 1'b0;
        wait_us(2);
        chk(rs_cnt == rs0, "R4 no reset flag for 400us low", rs_cnt, rs0);
        wait_us(43);
        chk(line_pull_o == 1'b0, "R4 no presence for 400us low", line_pull_o, 0);
        wait_us(150);
        chk(line_pull_o == 1'b0, "R4 still released", line_pull_o, 0);

        // R9: reset starting as a read-0 slot
        slot_dir = 1'b1;
        tx_bit = 1'b0;
        do_reset(520, 1'b0, "R9");

        // R10: master pulse hidden inside presence
        slot_dir = 1'b0;
        do_reset(490, 1'b1, "R10");

        do_slot(1'b0, 1'b1);

        for (int i = 0; i < 110; i++) begin
            do_slot(1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule